// File: doc/BRIEF.md
# CAN Bit Stuffing Codec

This block handles bit stuffing for a CAN controller. The transmit path sits between the frame serializer and the bus driver. When the serializer has sent five equal bits in a row inside the stuffed part of a frame, the block inserts one bit of the opposite value. The inserted bits make sure the bus has edges that receivers can resynchronize on. The receive path sits between the bit sampler and the frame parser. It drops the inserted bits, so the parser sees only frame content. If a sixth equal level arrives where a stuff bit belongs, it reports a stuff error. This applies to both polarities: dominant (0) runs and recessive (1) runs.

Each direction is driven by a one-cycle slot strobe from the bit timing logic.

- **Enable input:** marks the part of the frame that is subject to stuffing.
- **Start-of-frame input:** restarts run counting.
- **Transmit ready:** during a slot that carries an inserted bit, the transmit side holds `tx_ready_o` low. The upstream source must then keep its bit for the next slot.

Both paths register their outputs. Results appear one clock after the slot strobe. CRC, bit timing and frame parsing are outside this block.

Top module: `can_stuff_codec`

## Requirements
- R1: Out of reset, `tx_bit_o` is recessive (1), `tx_ready_o` is 1, and `tx_stb_o`, `rx_vld_o` and `rx_err_o` are 0.
- R2: After RUN_LEN (default 5) consecutive equal bits are emitted with stuffing enabled, the next transmit slot has `tx_ready_o` = 0. That slot emits the complement of the last bit, and `tx_data_i` is not consumed.
- R3: An inserted stuff bit counts as the first bit of a new run. Example: 00000, stuff 1, then four data 1s leads to a stuff 0.
- R4: Stuffing applies to runs of dominant (0) bits and to runs of recessive (1) bits alike.
- R5: With enable low, bits pass unchanged, no stuff bit is inserted and the run count stays cleared. A stuff bit that was already due when enable fell is still inserted in the next slot.
- R6: `sof_i` during a slot makes that slot's bit the first of a new run. Any pending stuff bit is discarded and `tx_ready_o` is 1 in that slot.
- R7: Receive data bits are delivered on `rx_data_o` with `rx_vld_o` = 1 one clock after their slot. A complementary bit in the stuff position is dropped, with no `rx_vld_o`.
- R8: An equal bit in the stuff position pulses `rx_err_o` for one clock and is not delivered. The run then restarts with that bit.
- R9: With receive enable low, every bit is delivered and `rx_err_o` stays 0.
- R10: `tx_stb_o` pulses one clock after each transmit slot. `tx_bit_o` holds its value between slots.
- R11: The receive path, fed with the transmit output and the same enable and start-of-frame pattern, delivers exactly the data bits the transmit path consumed, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_slot_i | input | 1 | One-cycle strobe per transmit bit slot |
| tx_en_i | input | 1 | Transmit stuffing region active |
| tx_sof_i | input | 1 | Restart transmit run counting |
| tx_data_i | input | 1 | Bit offered by the frame serializer |
| tx_ready_o | output | 1 | Offered bit is consumed in this slot |
| tx_bit_o | output | 1 | Bus bit to drive, held between slots |
| tx_stb_o | output | 1 | `tx_bit_o` was updated this cycle |
| rx_slot_i | input | 1 | One-cycle strobe per received bit |
| rx_en_i | input | 1 | Receive stuffing region active |
| rx_sof_i | input | 1 | Restart receive run counting |
| rx_bit_i | input | 1 | Sampled bus bit |
| rx_data_o | output | 1 | Destuffed data bit |
| rx_vld_o | output | 1 | `rx_data_o` holds a data bit |
| rx_err_o | output | 1 | Stuff violation pulse |

## Verification
The assertions assume the following about the inputs:
- Slot strobes last exactly one clock and are separated by at least one idle clock.
- `sof_i` and `en_i` are meaningful only while a slot is strobed.
- RUN_LEN is at least 2, so a stuff bit can never itself complete a run.

The bench meets these assumptions:
- Every slot is driven from a task that raises the strobe for one cycle and then lowers it.
- Enable changes and start-of-frame are applied only with a slot.
- Bits come from a biased random source, so long runs, stuff positions and receive violations occur often.

// File: rtl/can_stuff_pkg.sv
package can_stuff_pkg;
  localparam int unsigned DEF_RUN_LEN = 5;
  localparam logic LVL_DOMINANT  = 1'b0;
  localparam logic LVL_RECESSIVE = 1'b1;

  function automatic int unsigned run_cnt_w(input int unsigned run_len);
    return $clog2(run_len + 1);
  endfunction
endpackage

// File: rtl/can_stuff_run.sv
// Tracks the current run of equal line bits and flags when a stuff slot is due.
module can_stuff_run
  import can_stuff_pkg::*;
#(
  parameter int unsigned RUN_LEN = DEF_RUN_LEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic sof_i,
  input  logic en_i,
  input  logic bit_i,
  output logic due_o,
  output logic last_o
);
  localparam int unsigned CW = run_cnt_w(RUN_LEN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          last_q, last_d;
  logic          due_q, due_d;

  always_comb begin
    cnt_d  = cnt_q;
    last_d = last_q;
    due_d  = due_q;
    if (adv_i) begin
      last_d = bit_i;
      if (sof_i)                            cnt_d = en_i ? CW'(1) : '0;
      else if (due_q)                       cnt_d = CW'(1); // stuff bit opens new run
      else if (!en_i)                       cnt_d = '0;
      else if (cnt_q != '0 && bit_i == last_q) cnt_d = cnt_q + CW'(1);
      else                                  cnt_d = CW'(1);
      due_d = en_i && (cnt_d == CW'(RUN_LEN));
    end else if (sof_i) begin
      cnt_d = '0;
      due_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      last_q <= LVL_RECESSIVE;
      due_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      last_q <= last_d;
      due_q  <= due_d;
    end
  end

  assign due_o  = due_q;
  assign last_o = last_q;
endmodule

// File: rtl/can_stuff_tx.sv
module can_stuff_tx
  import can_stuff_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slot_i,
  input  logic sof_i,
  input  logic data_i,
  input  logic due_i,
  input  logic last_i,
  output logic line_o,
  output logic ready_o,
  output logic bit_o,
  output logic stb_o
);
  logic ins_stuff;

  assign ins_stuff = due_i && !sof_i;
  assign ready_o   = !ins_stuff;
  assign line_o    = ins_stuff ? ~last_i : data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o <= LVL_RECESSIVE;
      stb_o <= 1'b0;
    end else begin
      stb_o <= slot_i;
      if (slot_i) bit_o <= line_o;
    end
  end
endmodule

// File: rtl/can_stuff_rx.sv
module can_stuff_rx
  import can_stuff_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slot_i,
  input  logic sof_i,
  input  logic bit_i,
  input  logic due_i,
  input  logic last_i,
  output logic data_o,
  output logic vld_o,
  output logic err_o
);
  logic stuff_pos;

  assign stuff_pos = due_i && !sof_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= LVL_RECESSIVE;
      vld_o  <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      vld_o <= slot_i && !stuff_pos;
      err_o <= slot_i && stuff_pos && (bit_i == last_i);
      if (slot_i && !stuff_pos) data_o <= bit_i;
    end
  end
endmodule

// File: rtl/can_stuff_codec.sv
module can_stuff_codec
  import can_stuff_pkg::*;
#(
  parameter int unsigned RUN_LEN = DEF_RUN_LEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_slot_i,
  input  logic tx_en_i,
  input  logic tx_sof_i,
  input  logic tx_data_i,
  output logic tx_ready_o,
  output logic tx_bit_o,
  output logic tx_stb_o,
  input  logic rx_slot_i,
  input  logic rx_en_i,
  input  logic rx_sof_i,
  input  logic rx_bit_i,
  output logic rx_data_o,
  output logic rx_vld_o,
  output logic rx_err_o
);
  logic tx_due, tx_last, tx_line;
  logic rx_due, rx_last;

  can_stuff_run #(.RUN_LEN(RUN_LEN)) u_tx_run (
    .clk_i, .rst_ni,
    .adv_i(tx_slot_i), .sof_i(tx_sof_i), .en_i(tx_en_i), .bit_i(tx_line),
    .due_o(tx_due), .last_o(tx_last)
  );

  can_stuff_tx u_tx (
    .clk_i, .rst_ni,
    .slot_i(tx_slot_i), .sof_i(tx_sof_i), .data_i(tx_data_i),
    .due_i(tx_due), .last_i(tx_last),
    .line_o(tx_line), .ready_o(tx_ready_o), .bit_o(tx_bit_o), .stb_o(tx_stb_o)
  );

  can_stuff_run #(.RUN_LEN(RUN_LEN)) u_rx_run (
    .clk_i, .rst_ni,
    .adv_i(rx_slot_i), .sof_i(rx_sof_i), .en_i(rx_en_i), .bit_i(rx_bit_i),
    .due_o(rx_due), .last_o(rx_last)
  );

  can_stuff_rx u_rx (
    .clk_i, .rst_ni,
    .slot_i(rx_slot_i), .sof_i(rx_sof_i), .bit_i(rx_bit_i),
    .due_i(rx_due), .last_i(rx_last),
    .data_o(rx_data_o), .vld_o(rx_vld_o), .err_o(rx_err_o)
  );
endmodule

// File: rtl/can_stuff_checker.sv
module can_stuff_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_slot_i,
  input logic tx_sof_i,
  input logic tx_ready_o,
  input logic tx_bit_o,
  input logic tx_stb_o,
  input logic rx_slot_i,
  input logic rx_sof_i,
  input logic rx_due_i,
  input logic rx_vld_o,
  input logic rx_err_o
);
  p_stb_after_slot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_slot_i |=> tx_stb_o);
  p_no_stb_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_slot_i |=> !tx_stb_o);
  p_bit_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_slot_i |=> $stable(tx_bit_o));
  p_stuff_flips_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_slot_i && !tx_ready_o) |=> (tx_bit_o != $past(tx_bit_o)));
  p_ready_after_stuff_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_slot_i && !tx_ready_o) |=> tx_ready_o);
  p_sof_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_sof_i |-> tx_ready_o);
  p_err_only_stuff_pos_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_slot_i && (!rx_due_i || rx_sof_i)) |=> !rx_err_o);
  p_err_excl_vld_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_err_o && rx_vld_o));
  p_vld_needs_slot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_vld_o |-> $past(rx_slot_i));
endmodule

bind can_stuff_codec can_stuff_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .tx_slot_i(tx_slot_i), .tx_sof_i(tx_sof_i), .tx_ready_o(tx_ready_o),
  .tx_bit_o(tx_bit_o), .tx_stb_o(tx_stb_o),
  .rx_slot_i(rx_slot_i), .rx_sof_i(rx_sof_i), .rx_due_i(rx_due),
  .rx_vld_o(rx_vld_o), .rx_err_o(rx_err_o)
);

// File: tb/can_stuff_codec_bench.sv
`timescale 1ns/1ps
module can_stuff_codec_bench;
  localparam int RUN_LEN = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_slot = 0, tx_en = 0, tx_sof = 0, tx_data = 1;
  logic rx_slot = 0, rx_en = 0, rx_sof = 0, rx_bit = 1;
  logic tx_ready, tx_bit, tx_stb, rx_data, rx_vld, rx_err;

  int n_checks = 0, n_errors = 0;
  bit done = 0;

  // reference run state per direction: 0 = transmit, 1 = receive
  int m_cnt [2];
  bit m_last[2];
  bit m_due [2];

  always #5 clk = ~clk;

  can_stuff_codec #(.RUN_LEN(RUN_LEN)) u_can_stuff_codec (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_slot_i(tx_slot), .tx_en_i(tx_en), .tx_sof_i(tx_sof), .tx_data_i(tx_data),
    .tx_ready_o(tx_ready), .tx_bit_o(tx_bit), .tx_stb_o(tx_stb),
    .rx_slot_i(rx_slot), .rx_en_i(rx_en), .rx_sof_i(rx_sof), .rx_bit_i(rx_bit),
    .rx_data_o(rx_data), .rx_vld_o(rx_vld), .rx_err_o(rx_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    for (int s = 0; s < 2; s++) begin
      m_cnt[s] = 0; m_last[s] = 1'b1; m_due[s] = 1'b0;
    end
  endfunction

  function automatic void model_adv(input int s, input bit sof, input bit en, input bit b);
    if (sof)                              m_cnt[s] = en ? 1 : 0;
    else if (m_due[s])                    m_cnt[s] = 1;
    else if (!en)                         m_cnt[s] = 0;
    else if (m_cnt[s] != 0 && b == m_last[s]) m_cnt[s] = m_cnt[s] + 1;
    else                                  m_cnt[s] = 1;
    m_last[s] = b;
    m_due[s]  = en && (m_cnt[s] == RUN_LEN);
  endfunction

  task automatic tx_step(input bit sof, input bit en, input bit d, input string tag,
                         output bit consumed, output bit line);
    bit stuff;
    @(negedge clk);
    tx_sof = sof; tx_en = en; tx_data = d; tx_slot = 1'b1;
    stuff = m_due[0] && !sof;
    line  = stuff ? ~m_last[0] : d;
    consumed = !stuff;
    #1;
    chk(tx_ready == !stuff, {tag, " ready"}, int'(tx_ready), int'(!stuff));
    @(posedge clk);
    model_adv(0, sof, en, line);
    @(negedge clk);
    tx_slot = 1'b0; tx_sof = 1'b0;
    chk(tx_stb == 1'b1 && tx_bit == line, {tag, " bit"}, int'({tx_stb, tx_bit}), int'({1'b1, line}));
  endtask

  task automatic rx_step(input bit sof, input bit en, input bit b, input string tag,
                         output bit vld, output bit dat);
    bit spos, e_vld, e_err;
    @(negedge clk);
    rx_sof = sof; rx_en = en; rx_bit = b; rx_slot = 1'b1;
    spos  = m_due[1] && !sof;
    e_vld = !spos;
    e_err = spos && (b == m_last[1]);
    @(posedge clk);
    model_adv(1, sof, en, b);
    @(negedge clk);
    rx_slot = 1'b0; rx_sof = 1'b0;
    chk(rx_vld == e_vld && rx_err == e_err && (!e_vld || rx_data == b), tag,
        int'({rx_vld, rx_err, rx_data}), int'({e_vld, e_err, b}));
    vld = rx_vld; dat = rx_data;
  endtask

  function automatic string tx_tag(input bit sof, input bit en);
    if (m_due[0] && !sof) return "R2";
    if (!en) return "R5";
    return "R10";
  endfunction

  function automatic string rx_tag(input bit sof, input bit en);
    if (m_due[1] && !sof) return "R8";
    if (!en) return "R9";
    return "R7";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    bit c, l, v, d, prev, en, sof;
    void'($urandom(32'h1c4a_5eed));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(tx_ready == 1 && tx_bit == 1 && tx_stb == 0, "R1 tx", int'({tx_ready, tx_bit, tx_stb}), 6);
    chk(rx_vld == 0 && rx_err == 0, "R1 rx", int'({rx_vld, rx_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_ready == 1 && tx_bit == 1 && tx_stb == 0, "R1 released", int'({tx_ready, tx_bit, tx_stb}), 6);

    // R2/R4 dominant run, then R3 stuff bit starts new run
    tx_step(1, 1, 0, "R4", c, l);
    for (int i = 0; i < 4; i++) tx_step(0, 1, 0, "R4", c, l);
    tx_step(0, 1, 0, "R2", c, l);
    chk(c == 0 && l == 1, "R2 stuff inserted", int'({c, l}), 1);
    for (int i = 0; i < 4; i++) tx_step(0, 1, 1, "R3", c, l);
    tx_step(0, 1, 1, "R3", c, l);
    chk(c == 0 && l == 0, "R3 stuff after four", int'({c, l}), 0);
    // R4 recessive run from sof
    tx_step(1, 1, 1, "R4", c, l);
    for (int i = 0; i < 4; i++) tx_step(0, 1, 1, "R4", c, l);
    tx_step(0, 1, 1, "R4", c, l);
    chk(c == 0 && l == 0, "R4 recessive stuff", int'({c, l}), 0);

    // R5 pending stuff survives enable drop, then no stuffing
    tx_step(1, 1, 1, "R5", c, l);
    for (int i = 0; i < 4; i++) tx_step(0, 1, 1, "R5", c, l);
    tx_step(0, 0, 1, "R5", c, l);
    chk(c == 0 && l == 0, "R5 pending stuff", int'({c, l}), 0);
    for (int i = 0; i < 10; i++) begin
      tx_step(0, 0, 0, "R5", c, l);
      chk(c == 1 && l == 0, "R5 pass through", int'({c, l}), 2);
    end

    // R6 sof restarts run and discards pending stuff
    tx_step(1, 1, 0, "R6", c, l);
    for (int i = 0; i < 3; i++) tx_step(0, 1, 0, "R6", c, l);
    tx_step(1, 1, 0, "R6", c, l);
    for (int i = 0; i < 4; i++) begin
      tx_step(0, 1, 0, "R6", c, l);
      chk(c == 1, "R6 no stuff across sof", int'(c), 1);
    end
    tx_step(1, 1, 1, "R6", c, l);
    chk(c == 1 && l == 1, "R6 pending discarded", int'({c, l}), 3);

    // R7 stuff bit dropped, R8 violation
    rx_step(1, 1, 1, "R7", v, d);
    for (int i = 0; i < 4; i++) rx_step(0, 1, 1, "R7", v, d);
    rx_step(0, 1, 0, "R7", v, d);
    chk(v == 0 && rx_err == 0, "R7 stuff dropped", int'({v, rx_err}), 0);
    rx_step(0, 1, 0, "R7", v, d);
    chk(v == 1 && d == 0, "R7 next data", int'({v, d}), 2);
    rx_step(1, 1, 0, "R8", v, d);
    for (int i = 0; i < 4; i++) rx_step(0, 1, 0, "R8", v, d);
    rx_step(0, 1, 0, "R8", v, d);
    chk(v == 0 && rx_err == 1, "R8 sixth equal", int'({v, rx_err}), 1);
    for (int i = 0; i < 4; i++) rx_step(0, 1, 0, "R8", v, d);
    rx_step(0, 1, 1, "R8", v, d);
    chk(v == 0 && rx_err == 0, "R8 run restarted", int'({v, rx_err}), 0);
    // R9 disabled region
    rx_step(1, 0, 1, "R9", v, d);
    for (int i = 0; i < 8; i++) begin
      rx_step(0, 0, 1, "R9", v, d);
      chk(v == 1 && rx_err == 0, "R9 delivered", int'({v, rx_err}), 2);
    end

    // random transmit
    prev = 0; en = 1;
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(39) == 0) en = ~en;
      sof = ($urandom_range(29) == 0);
      if ($urandom_range(7) == 0) prev = ~prev;
      tx_step(sof, en, prev, tx_tag(sof, en), c, l);
    end
    // random receive (violations occur)
    en = 1;
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(39) == 0) en = ~en;
      sof = ($urandom_range(29) == 0);
      if ($urandom_range(6) == 0) prev = ~prev;
      rx_step(sof, en, prev, rx_tag(sof, en), v, d);
    end
    // R11 round trip
    en = 1;
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(39) == 0) en = ~en;
      sof = (i == 0) || ($urandom_range(29) == 0);
      if ($urandom_range(7) == 0) prev = ~prev;
      tx_step(sof, en, prev, "R11 tx", c, l);
      rx_step(sof, en, l, "R11 rx", v, d);
      chk(v == c && (!c || d == prev) && rx_err == 0, "R11 round trip",
          int'({v, d}), int'({c, prev}));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule